// File: doc/BRIEF.md
# SPI Master with Transmit and Receive FIFOs

This block is a synchronous serial port that works as a bus master in the common four-wire SPI format. Software programs it through a small register bus that is one word wide. Frames written to the data register enter an eight-entry transmit queue. A shift engine sends each queued frame most significant bit first on `mosi` and collects one frame from `miso` at the same time. It places that frame in an eight-entry receive queue. A status word lets software keep both queues moving during the same transfer. Chip select is not part of the block and is driven by software.

The serial clock comes from two dividers in series. The first divides by an even prescale value. The second divides by one plus a rate field in the first control register. Clock polarity and clock phase come from two control bits, so all four SPI modes are supported. The frame length ranges from 4 to 16 bits.

The register bus has no handshake. Back-pressure is given only through status bits, and the block does not stall the bus. Software checks "transmit not full" before it writes. A write to a full transmit queue is discarded. Software checks "receive not empty" before it reads. A read from an empty receive queue returns 0 and removes nothing. When the receive queue is full and a frame finishes, that frame is dropped and a sticky overrun flag is set.

Top module: `spi_fifo_master`

## Requirements
- R1: Register word offsets are 0x00 control A, 0x04 control B, 0x08 data, 0x0C status and 0x10 prescale. After reset the status word reads 0x03, the prescale register reads 2, and `sclk` is low.
- R2: The prescale register ignores bit 0 and always reads that bit as 0. A stored value of 0 acts as a prescale of 2.
- R3: While a frame is shifting, each half period of `sclk` lasts (prescale/2)×(1+rate) clock cycles. Rate is control A bits [15:8]. When no frame is shifting, `sclk` rests at the polarity level in control A bit 6.
- R4: With phase 0 (control A bit 7 = 0), `mosi` holds the first bit before the first `sclk` edge. `miso` is sampled on the leading edges, and `mosi` changes on the trailing edges.
- R5: With phase 1, `mosi` changes on the leading edges, and `miso` is sampled on the trailing edges.
- R6: Frames are shifted most significant bit first. Control A bits [3:0] hold the frame length minus one. A code below 3 gives 4-bit frames.
- R7: A write to the data register adds the low frame bits to the transmit queue, which holds eight entries. A write to a full queue is discarded. Status bit 0 means transmit empty, and status bit 1 means transmit not full.
- R8: A read of the data register removes the oldest received frame and returns it. A read when the queue is empty returns 0. Status bit 2 means receive not empty, and status bit 3 means receive full.
- R9: Each transmitted frame produces exactly one received frame. If the receive queue is full, that frame is dropped and the overrun flag is set. The flag is bit 2 of the word at 0x14. Writing 1 to that bit clears the flag.
- R10: Status bit 4 (busy) is 1 while a frame is shifting or the transmit queue is not empty.
- R11: Control B bit 4 enables the port. While it is 0, no frame starts, a frame in progress stops, `sclk` stays at the polarity level, and queued data remains in the queue.
- R12: When the next frame is already queued as a frame ends, it follows with no idle time beyond the normal half period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_en | input | 1 | Register access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address; bits [4:2] select the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for the register at `bus_addr` |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
The bench uses the default parameters: 8-entry queues, a 4-bit length code that allows frames up to 16 bits, and 8-bit divider fields. With these values, nine frames are enough to fill both queues and cause an overrun. Random bursts cover all four polarity and phase combinations, frame lengths from 4 to 16 bits, and prescale values 0 to 8. An independent slave model checks the timing of every `sclk` edge during these bursts.

// File: rtl/spi_fifo_pkg.sv
package spi_fifo_pkg;
  localparam int unsigned REG_IDX_W = 3;
  localparam logic [REG_IDX_W-1:0] RI_CTLA  = 3'd0;
  localparam logic [REG_IDX_W-1:0] RI_CTLB  = 3'd1;
  localparam logic [REG_IDX_W-1:0] RI_DATA  = 3'd2;
  localparam logic [REG_IDX_W-1:0] RI_STAT  = 3'd3;
  localparam logic [REG_IDX_W-1:0] RI_PRESC = 3'd4;
  localparam logic [REG_IDX_W-1:0] RI_FLAGS = 3'd5;

  localparam int unsigned CPOL_BIT = 6;
  localparam int unsigned CPHA_BIT = 7;
  localparam int unsigned RATE_LSB = 8;
  localparam int unsigned EN_BIT   = 4;
  localparam int unsigned OVR_BIT  = 2;

  localparam int unsigned ST_TX_EMPTY = 0;
  localparam int unsigned ST_TX_ROOM  = 1;
  localparam int unsigned ST_RX_AVAIL = 2;
  localparam int unsigned ST_RX_FULL  = 3;
  localparam int unsigned ST_BUSY     = 4;

  typedef enum logic {SH_IDLE, SH_RUN} sh_state_e;
endpackage

// File: rtl/spi_sync_fifo.sv
module spi_sync_fifo #(
  parameter int unsigned WIDTH = 16,
  parameter int unsigned DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [WIDTH-1:0] push_data,
  input  logic             pop,
  output logic [WIDTH-1:0] head,
  output logic             empty,
  output logic             full
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] count;
  logic             do_push, do_pop;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  assign empty   = (count == '0);
  assign full    = (count == CNT_W'(DEPTH));
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign head    = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= bump(wr_ptr);
      if (do_pop)  rd_ptr <= bump(rd_ptr);
      case ({do_push, do_pop})
        2'b10:   count <= count + CNT_W'(1);
        2'b01:   count <= count - CNT_W'(1);
        default: ;
      endcase
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop) |=> (count == $past(count))); // R7
  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(DEPTH)); // R7
endmodule

// File: rtl/spi_rate_gen.sv
module spi_rate_gen #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] presc,
  input  logic [DIV_W-1:0] rate,
  output logic             tick
);
  localparam int unsigned HALF_W = DIV_W - 1;

  logic [HALF_W-1:0] pre_cnt;
  logic [HALF_W-1:0] pre_last;
  logic [DIV_W-1:0]  rate_cnt;
  logic              pre_wrap, rate_wrap;

  assign pre_last  = presc[DIV_W-1:1] - HALF_W'(1);
  assign pre_wrap  = (pre_cnt >= pre_last);
  assign rate_wrap = (rate_cnt >= rate);
  assign tick      = run && pre_wrap && rate_wrap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_cnt  <= '0;
      rate_cnt <= '0;
    end else if (!run) begin
      pre_cnt  <= '0;
      rate_cnt <= '0;
    end else if (pre_wrap) begin
      pre_cnt  <= '0;
      rate_cnt <= rate_wrap ? '0 : rate_cnt + DIV_W'(1);
    end else begin
      pre_cnt <= pre_cnt + HALF_W'(1);
    end
  end
endmodule

// File: rtl/spi_frame_shifter.sv
module spi_frame_shifter
  import spi_fifo_pkg::*;
#(
  parameter int unsigned SIZE_CODE_W = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          en,
  input  logic                          cpol,
  input  logic                          cpha,
  input  logic [SIZE_CODE_W-1:0]        size_code,
  input  logic                          tick,
  input  logic                          tx_valid,
  input  logic [(1<<SIZE_CODE_W)-1:0]   tx_data,
  output logic                          tx_pop,
  output logic                          run,
  output logic                          rx_valid,
  output logic [(1<<SIZE_CODE_W)-1:0]   rx_data,
  output logic                          sclk,
  output logic                          mosi,
  input  logic                          miso
);
  localparam int unsigned MAX_BITS = 1 << SIZE_CODE_W;
  localparam int unsigned SZ_W     = SIZE_CODE_W + 1;
  localparam int unsigned CNT_W    = SIZE_CODE_W + 2;

  sh_state_e             state;
  logic [MAX_BITS-1:0]   tx_sh, rx_sh, rx_next, rx_mask, ld_sh;
  logic [CNT_W-1:0]      edge_cnt, edge_last;
  logic [SZ_W-1:0]       nbits;
  logic                  sclk_ph, mosi_q, ld_mosi;
  logic                  leading, sample_now, shift_now, last_edge, frame_done;

  always_comb begin
    nbits      = (size_code < SIZE_CODE_W'(3)) ? SZ_W'(4) : SZ_W'(size_code) + SZ_W'(1);
    edge_last  = {nbits, 1'b0} - CNT_W'(1);
    rx_mask    = ~({MAX_BITS{1'b1}} << nbits);
    leading    = !edge_cnt[0];
    sample_now = tick && (leading ^ cpha);
    shift_now  = tick && !(leading ^ cpha);
    last_edge  = (edge_cnt == edge_last);
    frame_done = en && (state == SH_RUN) && tick && last_edge;
    rx_next    = {rx_sh[MAX_BITS-2:0], miso};
    ld_sh      = cpha ? tx_data : {tx_data[MAX_BITS-2:0], 1'b0};
    ld_mosi    = cpha ? mosi_q : tx_data[nbits-SZ_W'(1)];
  end

  assign tx_pop   = en && tx_valid && ((state == SH_IDLE) || frame_done);
  assign run      = (state == SH_RUN);
  assign rx_valid = frame_done;
  assign rx_data  = (cpha ? rx_next : rx_sh) & rx_mask;
  assign sclk     = cpol ^ sclk_ph;
  assign mosi     = mosi_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= SH_IDLE;
      tx_sh    <= '0;
      rx_sh    <= '0;
      edge_cnt <= '0;
      sclk_ph  <= 1'b0;
      mosi_q   <= 1'b0;
    end else if (!en) begin
      state    <= SH_IDLE;
      edge_cnt <= '0;
      sclk_ph  <= 1'b0;
    end else begin
      case (state)
        SH_IDLE: begin
          if (tx_valid) begin
            state    <= SH_RUN;
            edge_cnt <= '0;
            sclk_ph  <= 1'b0;
            tx_sh    <= ld_sh;
            mosi_q   <= ld_mosi;
          end
        end
        default: begin
          if (tick) begin
            sclk_ph <= ~sclk_ph;
            if (sample_now) rx_sh <= rx_next;
            if (last_edge) begin
              edge_cnt <= '0;
              if (tx_valid) begin
                tx_sh  <= ld_sh;
                mosi_q <= ld_mosi;
              end else begin
                state <= SH_IDLE;
              end
            end else begin
              edge_cnt <= edge_cnt + CNT_W'(1);
              if (shift_now) begin
                mosi_q <= tx_sh[nbits-SZ_W'(1)];
                tx_sh  <= {tx_sh[MAX_BITS-2:0], 1'b0};
              end
            end
          end
        end
      endcase
    end
  end

  AST_SCLK_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state == SH_RUN) && !$past(tick) && state == SH_RUN) |-> (sclk_ph == $past(sclk_ph))); // R3
  AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    (state == SH_IDLE) |-> (sclk == cpol)); // R3
  AST_EN_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (state == SH_IDLE)); // R11
endmodule

// File: rtl/spi_fifo_master.sv
module spi_fifo_master
  import spi_fifo_pkg::*;
#(
  parameter int unsigned ADDR_W      = 5,
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned FIFO_DEPTH  = 8,
  parameter int unsigned SIZE_CODE_W = 4,
  parameter int unsigned DIV_W       = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso
);
  localparam int unsigned MAX_BITS = 1 << SIZE_CODE_W;
  localparam int unsigned PRE_HI_W = DIV_W - 1;

  logic [REG_IDX_W-1:0]   reg_idx;
  logic                   wr_cyc, rd_cyc, ovr_clear;
  logic [SIZE_CODE_W-1:0] size_code;
  logic                   cpol, cpha, port_en, ovr;
  logic [DIV_W-1:0]       rate, presc_eff;
  logic [PRE_HI_W-1:0]    presc_hi;

  logic                   tx_push, tx_pop, tx_empty, tx_full;
  logic [MAX_BITS-1:0]    tx_head;
  logic                   rx_pop, rx_empty, rx_full, rx_done;
  logic [MAX_BITS-1:0]    rx_head, rx_word;
  logic                   sh_run, tick, busy;

  assign reg_idx   = bus_addr[2 +: REG_IDX_W];
  assign wr_cyc    = bus_en && bus_we;
  assign rd_cyc    = bus_en && !bus_we;
  assign tx_push   = wr_cyc && (reg_idx == RI_DATA);
  assign rx_pop    = rd_cyc && (reg_idx == RI_DATA);
  assign ovr_clear = wr_cyc && (reg_idx == RI_FLAGS) && bus_wdata[OVR_BIT];
  assign presc_eff = (presc_hi == '0) ? DIV_W'(2) : {presc_hi, 1'b0};
  assign busy      = sh_run || !tx_empty;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      size_code <= SIZE_CODE_W'(7);
      cpol      <= 1'b0;
      cpha      <= 1'b0;
      rate      <= '0;
      port_en   <= 1'b0;
      presc_hi  <= PRE_HI_W'(1);
      ovr       <= 1'b0;
    end else begin
      if (wr_cyc) begin
        case (reg_idx)
          RI_CTLA: begin
            size_code <= bus_wdata[SIZE_CODE_W-1:0];
            cpol      <= bus_wdata[CPOL_BIT];
            cpha      <= bus_wdata[CPHA_BIT];
            rate      <= bus_wdata[RATE_LSB +: DIV_W];
          end
          RI_CTLB:  port_en  <= bus_wdata[EN_BIT];
          RI_PRESC: presc_hi <= bus_wdata[DIV_W-1:1];
          default:  ;
        endcase
      end
      if (rx_done && rx_full) ovr <= 1'b1;
      else if (ovr_clear)     ovr <= 1'b0;
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (reg_idx)
      RI_CTLA: begin
        bus_rdata[SIZE_CODE_W-1:0]    = size_code;
        bus_rdata[CPOL_BIT]           = cpol;
        bus_rdata[CPHA_BIT]           = cpha;
        bus_rdata[RATE_LSB +: DIV_W]  = rate;
      end
      RI_CTLB: bus_rdata[EN_BIT] = port_en;
      RI_DATA: if (!rx_empty) bus_rdata[MAX_BITS-1:0] = rx_head;
      RI_STAT: begin
        bus_rdata[ST_TX_EMPTY] = tx_empty;
        bus_rdata[ST_TX_ROOM]  = !tx_full;
        bus_rdata[ST_RX_AVAIL] = !rx_empty;
        bus_rdata[ST_RX_FULL]  = rx_full;
        bus_rdata[ST_BUSY]     = busy;
      end
      RI_PRESC: bus_rdata[DIV_W-1:0] = {presc_hi, 1'b0};
      RI_FLAGS: bus_rdata[OVR_BIT]   = ovr;
      default: ;
    endcase
  end

  spi_sync_fifo #(.WIDTH(MAX_BITS), .DEPTH(FIFO_DEPTH)) i_tx_fifo (
    .clk(clk), .rst_n(rst_n),
    .push(tx_push), .push_data(bus_wdata[MAX_BITS-1:0]),
    .pop(tx_pop), .head(tx_head), .empty(tx_empty), .full(tx_full)
  );

  spi_sync_fifo #(.WIDTH(MAX_BITS), .DEPTH(FIFO_DEPTH)) i_rx_fifo (
    .clk(clk), .rst_n(rst_n),
    .push(rx_done), .push_data(rx_word),
    .pop(rx_pop), .head(rx_head), .empty(rx_empty), .full(rx_full)
  );

  spi_rate_gen #(.DIV_W(DIV_W)) i_rate_gen (
    .clk(clk), .rst_n(rst_n), .run(sh_run),
    .presc(presc_eff), .rate(rate), .tick(tick)
  );

  spi_frame_shifter #(.SIZE_CODE_W(SIZE_CODE_W)) i_shifter (
    .clk(clk), .rst_n(rst_n), .en(port_en),
    .cpol(cpol), .cpha(cpha), .size_code(size_code), .tick(tick),
    .tx_valid(!tx_empty), .tx_data(tx_head), .tx_pop(tx_pop),
    .run(sh_run), .rx_valid(rx_done), .rx_data(rx_word),
    .sclk(sclk), .mosi(mosi), .miso(miso)
  );

  AST_OVR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr) |-> $past(rx_full)); // R9
  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr && !ovr_clear) |=> ovr); // R9
endmodule

// File: tb/test_spi_fifo_master.sv
module test_spi_fifo_master;
  localparam logic [2:0] A_CTLA = 3'd0, A_CTLB = 3'd1, A_DATA = 3'd2,
                         A_STAT = 3'd3, A_PRE = 3'd4, A_FLG = 3'd5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_en = 1'b0, bus_we = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        sclk, mosi;
  logic        miso = 1'b0;

  always #2 clk = ~clk;

  spi_fifo_master i_spi_fifo_master (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .sclk(sclk), .mosi(mosi), .miso(miso)
  );

  int checks = 0, fails = 0;
  bit done_flag = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=hung expected=finished");
    finish_run();
  end

  task automatic wr(input logic [2:0] idx, input logic [31:0] d);
    @(negedge clk);
    bus_en = 1; bus_we = 1; bus_addr = {idx, 2'b00}; bus_wdata = d;
    @(negedge clk);
    bus_en = 0; bus_we = 0;
  endtask

  task automatic rd(input logic [2:0] idx, output logic [31:0] d);
    @(negedge clk);
    bus_en = 1; bus_we = 0; bus_addr = {idx, 2'b00};
    #1 d = bus_rdata;
    @(negedge clk);
    bus_en = 0;
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    s = 32'h10;
    while (s[4]) rd(A_STAT, s);
  endtask

  function automatic logic [15:0] mask_n(input int n);
    return 16'((32'd1 << n) - 1);
  endfunction

  function automatic int bits_of(input int code);
    return (code < 3) ? 4 : code + 1;
  endfunction

  function automatic logic [15:0] slave_word(input int idx, input int n);
    return 16'(idx * 40503 + 4660) & mask_n(n);
  endfunction

  function automatic int eff_presc(input int p);
    int v;
    v = p & 32'hFE;
    return (v < 2) ? 2 : v;
  endfunction

  // independent slave model
  int          s_n = 8;
  logic        s_cpha = 0;
  logic        s_arm = 0;
  int          s_edge, s_ptr, s_frame = 0, cap_cnt = 0, gap_err = 0;
  logic [15:0] s_word, s_rx;
  logic [15:0] cap_mosi [16];
  time         s_last, half_t;
  bit          s_last_ok = 0;

  task automatic slave_reset();
    s_edge = 0;
    s_rx   = '0;
    s_word = slave_word(s_frame, s_n);
    if (!s_cpha) begin
      miso  = s_word[s_n-1];
      s_ptr = s_n - 2;
    end else begin
      s_ptr = s_n - 1;
    end
  endtask

  always @(sclk) begin
    if (s_arm) begin
      if (s_last_ok && (($time - s_last) != half_t)) gap_err++;
      s_last = $time;
      s_last_ok = 1;
      s_edge++;
      if (((s_edge % 2) == 1) ^ s_cpha) s_rx = {s_rx[14:0], mosi};
      else if (s_edge != 2 * s_n) begin
        if (s_ptr >= 0) miso = s_word[s_ptr];
        s_ptr--;
      end
      if (s_edge == 2 * s_n) begin
        if (cap_cnt < 16) cap_mosi[cap_cnt] = s_rx & mask_n(s_n);
        cap_cnt++;
        s_frame++;
        slave_reset();
      end
    end
  end

  task automatic setup(input bit pol, input bit pha, input int code, input int presc, input int rate);
    s_arm = 0;
    wr(A_CTLB, 32'h0);
    wr(A_CTLA, {16'h0, 8'(rate), pha, pol, 2'b00, 4'(code)});
    wr(A_PRE, 32'(presc));
    repeat (2) @(negedge clk);
    s_n = bits_of(code);
    s_cpha = pha;
    cap_cnt = 0;
    gap_err = 0;
    s_last_ok = 0;
    half_t = time'((eff_presc(presc) / 2) * (rate + 1) * 4);
    slave_reset();
    s_arm = 1;
  endtask

  task automatic burst(input bit pol, input bit pha, input int code, input int presc,
                       input int rate, input int nfr);
    logic [15:0] sent [8];
    logic [31:0] r;
    int base;
    setup(pol, pha, code, presc, rate);
    base = s_frame;
    for (int i = 0; i < nfr; i++) begin
      sent[i] = 16'($urandom);
      wr(A_DATA, {16'h0, sent[i]});
    end
    wr(A_CTLB, 32'h10);
    rd(A_STAT, r);
    chk("R10 busy while frames queued", 32'(r[4]), 32'h1);
    wait_idle();
    chk("R9 one frame per write", 32'(cap_cnt), 32'(nfr));
    chk("R3/R12 half period and no gaps", 32'(gap_err), 32'h0);
    chk("R3 sclk rests at polarity", 32'(sclk), 32'(pol));
    for (int i = 0; i < nfr && i < 8; i++) begin
      chk(pha ? "R5/R6 mosi frame" : "R4/R6 mosi frame",
          32'(cap_mosi[i]), 32'(sent[i] & mask_n(s_n)));
      rd(A_DATA, r);
      chk(pha ? "R5/R8 rx frame" : "R4/R8 rx frame", r, 32'(slave_word(base + i, s_n)));
    end
  endtask

  initial begin
    logic [31:0] r;
    int base;
    void'($urandom(32'h5EED));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    rd(A_STAT, r);  chk("R1 status after reset", r, 32'h03);
    rd(A_PRE, r);   chk("R1 prescale after reset", r, 32'h02);
    chk("R1 sclk after reset", 32'(sclk), 32'h0);
    rd(A_DATA, r);  chk("R8 empty read returns 0", r, 32'h0);

    // R2 prescale readback
    wr(A_PRE, 32'h5); rd(A_PRE, r); chk("R2 bit 0 ignored", r, 32'h4);
    wr(A_PRE, 32'h1); rd(A_PRE, r); chk("R2 value 1 reads 0", r, 32'h0);

    // R11 disabled port holds data
    setup(1'b1, 1'b0, 7, 4, 1);
    wr(A_DATA, 32'hA5);
    repeat (100) @(negedge clk);
    chk("R11 no frame while disabled", 32'(cap_cnt), 32'h0);
    chk("R11 sclk idle while disabled", 32'(sclk), 32'h1);
    rd(A_STAT, r); chk("R11 data stays queued", r & 32'h1, 32'h0);
    wr(A_CTLB, 32'h10);
    wait_idle();
    rd(A_DATA, r); 

    // R7 transmit queue full, ninth write dropped
    setup(1'b0, 1'b0, 7, 2, 0);
    base = s_frame;
    for (int i = 0; i < 9; i++) wr(A_DATA, 32'(8'h10 + i));
    rd(A_STAT, r); chk("R7 status with full tx queue", r, 32'h10);
    wr(A_CTLB, 32'h10);
    wait_idle();
    chk("R7 ninth write dropped", 32'(cap_cnt), 32'h8);
    chk("R7 last sent frame", 32'(cap_mosi[7]), 32'h17);
    rd(A_STAT, r); chk("R8 status with full rx queue", r, 32'h0F);

    // R9 overrun
    wr(A_DATA, 32'h3C);
    wait_idle();
    chk("R9 frame still sent", 32'(cap_cnt), 32'h9);
    rd(A_FLG, r); chk("R9 overrun flag set", r, 32'h4);
    for (int i = 0; i < 8; i++) begin
      rd(A_DATA, r);
      chk("R9 kept frames in order", r, 32'(slave_word(base + i, 8)));
    end
    rd(A_STAT, r); chk("R8 rx drained", r & 32'h4, 32'h0);
    wr(A_FLG, 32'h4); rd(A_FLG, r); chk("R9 overrun cleared", r, 32'h0);

    // directed modes and sizes
    burst(1'b0, 1'b0, 7, 2, 0, 4);
    burst(1'b1, 1'b1, 15, 6, 1, 3);
    burst(1'b0, 1'b1, 1, 0, 2, 5);   // R6 short code gives 4 bits, R2 zero prescale
    burst(1'b1, 1'b0, 3, 8, 0, 8);

    // constrained random
    for (int k = 0; k < 12; k++) begin
      burst(1'($urandom), 1'($urandom), 3 + int'($urandom % 13), int'($urandom % 9),
            int'($urandom % 4), 1 + int'($urandom % 8));
    end

    finish_run();
  end
endmodule